// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets a clocked host read and write an external asynchronous static RAM of 131,072 bytes. The host offers one transaction at a time over a request/ready handshake: an address, a write flag and write data. A read returns its byte on a registered output, marked by a one-cycle valid strobe. On the memory side the block drives three active-low controls (chip enable, write enable, output enable) and a 17-bit address. The 8-bit bidirectional data bus is presented as separate output, input and tri-state enable pins, and the pad ring merges them.

Every memory timing minimum is a parameter in nanoseconds. A clock-period parameter turns each one into a whole number of cycles, rounded up, with a floor of one cycle. Writes are write-enable-controlled: chip enable stays low across the whole pulse, and the byte is taken when write enable rises. The address changes only while chip enable is high. The data drivers turn on only while output enable is high, so they never fight the memory's own outputs.

Top module: `sram_async_ctl`

## Requirements
- R1: In reset and while idle, chip enable, write enable and output enable are all high (1), the data drivers are off (memDataOe = 0), reqReady is 1 and rspValid is 0.
- R2: A byte written to an address is returned by a later read of that address, including addresses 0 and 0x1FFFF, and a second write to an address replaces the first.
- R3: Write enable is low only while chip enable is low, and chip enable remains low in the cycle where write enable rises.
- R4: The memory address does not change between two consecutive cycles in which write enable is low.
- R5: Each write pulse satisfies three minimums before write enable rises: write enable is low for at least tWP (7 ns), the data drivers are on for at least tDW (5 ns) of that low time, and the address is valid with chip enable low for at least tAW (8 ns).
- R6: memDataOe is 1 only while output enable is high, and never in the cycle after a cycle in which output enable was low. This gives at least one turnaround cycle after a read.
- R7: A read holds output enable low for max(tAA, tOE) worth of cycles. It samples memDataIn at the last of those cycles, and then drives rspValid high for exactly one cycle with the sampled byte on rspData.
- R8: Only one transaction is in flight. reqReady is 0 from the accepting edge until the controller returns to idle, and reqValid presented while reqReady is 0 starts nothing.
- R9: With the default 5 ns clock, a write keeps reqReady low for 4 cycles (1 setup, 2 pulse, 1 recovery), and rspValid rises 2 cycles after a read is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host offers a transaction |
| reqReady | output | 1 | Controller idle and able to accept |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Byte address |
| reqWdata | input | 8 | Byte to write |
| rspValid | output | 1 | One-cycle strobe: rspData holds read data |
| rspData | output | 8 | Registered read data |
| memCeN | output | 1 | Memory chip enable, active low |
| memWeN | output | 1 | Memory write enable, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memAddr | output | 17 | Memory address |
| memDataOut | output | 8 | Data driven toward the memory |
| memDataOe | output | 1 | Tri-state enable for memDataOut |
| memDataIn | input | 8 | Data seen on the memory bus |

## Verification
The first pattern is a set of isolated writes followed by isolated reads, at the two end addresses and in the middle. It shows whether storage and address decoding are right, and it checks latency with no neighbouring traffic. The second pattern puts a read directly before a write. Here the turnaround cycle can be told apart from a controller that drives the bus while the memory is still driving it. The third pattern is a back-to-back overwrite of one address, which separates correct capture on the rising edge of write enable from stale data. The fourth pattern raises a second request while a write is still busy, which exposes any controller that accepts overlapping work or lets the address move during the pulse. The behavioural memory model returns a poison byte until the access time has elapsed, so a read sampled too early shows up as a data mismatch.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WEND,
    ST_READ
  } ctlState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // take host request into address/data registers
    logic capture;  // sample memory data into the response register
    logic ceN;
    logic weN;
    logic oeN;
    logic drive;    // enable data drivers
  } ctlStrobe_t;

  function automatic int nsToCycles(input int ns, input int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS   = 5,
  parameter int T_WP_NS  = 7,
  parameter int T_DW_NS  = 5,
  parameter int T_AW_NS  = 8,
  parameter int T_WC_NS  = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_OE_NS  = 5,
  parameter int T_OHZ_NS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output ctlStrobe_t stb
);

  localparam int CYC_SETUP = nsToCycles(T_OHZ_NS, CLK_NS);
  localparam int CYC_PULSE_MIN = maxOf(nsToCycles(T_WP_NS, CLK_NS),
                                       maxOf(nsToCycles(T_DW_NS, CLK_NS),
                                             nsToCycles(T_AW_NS, CLK_NS)));
  localparam int CYC_PULSE = maxOf(CYC_PULSE_MIN,
                                   nsToCycles(T_WC_NS, CLK_NS) - CYC_SETUP - 1);
  localparam int CYC_READ  = maxOf(nsToCycles(T_AA_NS, CLK_NS),
                                   nsToCycles(T_OE_NS, CLK_NS));
  localparam int MAX_CYC   = maxOf(CYC_SETUP, maxOf(CYC_PULSE, CYC_READ));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  ctlState_e stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic cntDone;

  assign cntDone = (cntQ == '0);

  always_comb begin
    stateD = stateQ;
    cntD   = cntDone ? '0 : cntQ - 1'b1;
    unique case (stateQ)
      ST_IDLE: begin
        cntD = '0;
        if (reqValid) begin
          stateD = reqWrite ? ST_WSETUP : ST_READ;
          cntD   = reqWrite ? CNT_W'(CYC_SETUP - 1) : CNT_W'(CYC_READ - 1);
        end
      end
      ST_WSETUP: if (cntDone) begin
        stateD = ST_WPULSE;
        cntD   = CNT_W'(CYC_PULSE - 1);
      end
      ST_WPULSE: if (cntDone) stateD = ST_WEND;
      ST_WEND:   stateD = ST_IDLE;
      ST_READ:   if (cntDone) stateD = ST_IDLE;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
    end
  end

  assign reqReady    = (stateQ == ST_IDLE);
  assign stb.load    = reqReady && reqValid;
  assign stb.capture = (stateQ == ST_READ) && cntDone;
  assign stb.ceN     = (stateQ == ST_IDLE);
  assign stb.weN     = (stateQ != ST_WPULSE);
  assign stb.oeN     = (stateQ != ST_READ);
  assign stb.drive   = (stateQ == ST_WPULSE) || (stateQ == ST_WEND);

  p_we_within_ce_r3: assert property (@(posedge clk) disable iff (!rstN)
    !stb.weN |-> !stb.ceN);

  p_one_in_flight_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_data_before_end_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stb.weN) |-> ($past(stb.drive) && !stb.ceN));

  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.oeN |=> !stb.drive);

endmodule

// File: rtl/sram_ctl_dp.sv
module sram_ctl_dp
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdataQ <= '0;
      validQ <= 1'b0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (stb.capture) rdataQ <= memDataIn;
      validQ <= stb.capture;
    end
  end

  assign memAddr    = addrQ;
  assign memDataOut = wdataQ;
  assign memDataOe  = stb.drive;
  assign memCeN     = stb.ceN;
  assign memWeN     = stb.weN;
  assign memOeN     = stb.oeN;
  assign rspData    = rdataQ;
  assign rspValid   = validQ;

  p_addr_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !$past(memWeN)) |-> $stable(memAddr));

  p_drive_oe_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    memDataOe |-> memOeN);

  p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
  import sram_ctl_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 5,
  parameter int T_WP_NS  = 7,
  parameter int T_DW_NS  = 5,
  parameter int T_AW_NS  = 8,
  parameter int T_WC_NS  = 10,
  parameter int T_AA_NS  = 10,
  parameter int T_OE_NS  = 5,
  parameter int T_OHZ_NS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDataOut,
  output logic              memDataOe,
  input  logic [DATA_W-1:0] memDataIn
);

  ctlStrobe_t stb;

  sram_ctl_fsm #(
    .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS), .T_AW_NS(T_AW_NS),
    .T_WC_NS(T_WC_NS), .T_AA_NS(T_AA_NS), .T_OE_NS(T_OE_NS), .T_OHZ_NS(T_OHZ_NS)
  ) i_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  sram_ctl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memWeN && memOeN && !memDataOe));

endmodule

// File: tb/test_sram_async_ctl.sv
module test_sram_async_ctl;

  localparam int CLK_PERIOD = 10;
  localparam int CLK_NS  = 5;
  localparam int T_WP    = 7;
  localparam int T_DW    = 5;
  localparam int T_AW    = 8;
  localparam int T_AA    = 10;
  localparam int WR_BUSY = 4;
  localparam int RD_LAT  = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [16:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, rspValid;
  logic [7:0]  rspData;
  logic        memCeN, memWeN, memOeN, memDataOe;
  logic [16:0] memAddr;
  logic [7:0]  memDataOut;
  logic [7:0]  memDataIn = 8'hEE;

  int compared = 0;
  int mismatched = 0;
  int cycleCnt = 0;

  sram_async_ctl i_sram_async_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memCeN(memCeN), .memWeN(memWeN),
    .memOeN(memOeN), .memAddr(memAddr), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .memDataIn(memDataIn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] modelMem [int];
  logic [7:0] refMem [int];
  logic pWeN = 1, pOeN = 1, pCeN = 1, pDrive = 0, pRead = 0;
  logic [16:0] pAddr = '0;
  logic [7:0]  pData = '0;
  int weLowCnt = 0, dataCnt = 0, addrCnt = 0, readCnt = 0;

  function automatic logic [7:0] memRead(input int a);
    return modelMem.exists(a) ? modelMem[a] : 8'h00;
  endfunction

  always @(negedge clk) if (rstN) begin
    logic readCond;
    readCond = !memCeN && memWeN && !memOeN;
    if (!memWeN && memCeN) check(0, "R3", "write enable low with chip enable high", 1, 0);
    if (!memWeN && !pWeN && memAddr != pAddr) check(0, "R4", "address moved during write", memAddr, pAddr);
    if (memDataOe && !memOeN) check(0, "R6", "bus contention", 1, 0);
    if (memDataOe && !pOeN) check(0, "R6", "no turnaround after read", 1, 0);
    if (memWeN && !pWeN) begin
      check(!memCeN, "R3", "chip enable held at write end", memCeN, 0);
      check(weLowCnt * CLK_NS >= T_WP, "R5", "write pulse ns", weLowCnt * CLK_NS, T_WP);
      check(dataCnt * CLK_NS >= T_DW, "R5", "data valid ns", dataCnt * CLK_NS, T_DW);
      check(addrCnt * CLK_NS >= T_AW, "R5", "address valid ns", addrCnt * CLK_NS, T_AW);
      modelMem[int'(pAddr)] = pData;
    end
    weLowCnt = !memWeN ? weLowCnt + 1 : 0;
    dataCnt  = (!memWeN && memDataOe) ? dataCnt + 1 : 0;
    addrCnt  = memCeN ? 0 : ((!pCeN && memAddr == pAddr) ? addrCnt + 1 : 1);
    readCnt  = readCond ? ((pRead && memAddr == pAddr) ? readCnt + 1 : 1) : 0;
    memDataIn = (readCond && readCnt * CLK_NS >= T_AA) ? memRead(int'(memAddr)) : 8'hEE;
    pWeN = memWeN; pOeN = memOeN; pCeN = memCeN; pAddr = memAddr;
    pData = memDataOut; pDrive = memDataOe; pRead = readCond;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] data; int when; } expItem_t;
  expItem_t expQ[$];
  logic pRsp = 0;

  always @(negedge clk) if (rstN) begin
    if (pRsp && rspValid) check(0, "R7", "rspValid longer than one cycle", 1, 0);
    if (rspValid) begin
      if (expQ.size() == 0) check(0, "R8", "unexpected response", rspData, 0);
      else begin
        expItem_t e;
        e = expQ.pop_front();
        check(rspData == e.data, "R2", "read data", rspData, e.data);
        check(cycleCnt - e.when == RD_LAT, "R9", "read latency", cycleCnt - e.when, RD_LAT);
      end
    end
    pRsp = rspValid;
  end

  // ---------------- driver ----------------
  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d, input int noise);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    check(!reqReady, "R8", "ready after accept", reqReady, 0);
    if (wr) refMem[int'(a)] = d;
    else expQ.push_back('{data: refMem.exists(int'(a)) ? refMem[int'(a)] : 8'h00, when: cycleCnt});
    // R8: stray request while busy, must be ignored
    reqWrite = 0; reqAddr = a ^ 17'h155;
    reqValid = (noise > 0);
    if (noise > 0) repeat (noise) @(negedge clk);
    reqValid = 0;
  endtask

  task automatic writeTimed(input logic [16:0] a, input logic [7:0] d);
    int busy;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    refMem[int'(a)] = d;
    @(negedge clk);
    reqValid = 0;
    busy = 0;
    while (!reqReady) begin busy++; @(negedge clk); end
    check(busy == WR_BUSY, "R9", "write busy cycles", busy, WR_BUSY);
  endtask

  task automatic drain();
    repeat (8) @(negedge clk);
    check(expQ.size() == 0, "R7", "responses outstanding", expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(memCeN && memWeN && memOeN, "R1", "controls in reset", {memCeN, memWeN, memOeN}, 7);
    check(!memDataOe && reqReady && !rspValid, "R1", "drivers/ready/valid in reset",
          {memDataOe, reqReady, rspValid}, 2);
    rstN = 1;
    repeat (2) @(negedge clk);
    check(memCeN && memWeN && memOeN && !memDataOe && reqReady, "R1", "idle after reset", memCeN, 1);

    writeTimed(17'h00000, 8'hA5);
    writeTimed(17'h1FFFF, 8'h5A);
    issue(1, 17'h0ABCD, 8'h3C, 0);
    issue(0, 17'h00000, 8'h00, 0);
    issue(0, 17'h1FFFF, 8'h00, 0);
    issue(0, 17'h0ABCD, 8'h00, 0);
    drain();
    // read immediately followed by write (turnaround, R6)
    issue(0, 17'h00000, 8'h00, 0);
    issue(1, 17'h00100, 8'h11, 0);
    issue(0, 17'h00100, 8'h00, 0);
    issue(1, 17'h00101, 8'h22, 0);
    // back-to-back overwrite (R2)
    issue(1, 17'h00100, 8'h77, 0);
    issue(1, 17'h00100, 8'h88, 0);
    issue(0, 17'h00100, 8'h00, 0);
    issue(0, 17'h00101, 8'h00, 0);
    drain();
    // stray requests while busy (R8)
    issue(1, 17'h12345, 8'hC3, 2);
    issue(0, 17'h12345, 8'h00, 1);
    for (int i = 0; i < 16; i++) issue(1, 17'(i * 977), 8'(i * 13 + 1), 0);
    for (int i = 0; i < 16; i++) issue(0, 17'(i * 977), 8'h00, 0);
    drain();
    check(memCeN && memWeN && memOeN && !memDataOe && reqReady, "R1", "idle at end", reqReady, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule